// File: doc/BRIEF.md
# Load and Multiply Result Interlock

This block sits beside the decode stage of a single-issue, in-order integer pipeline. Each cycle it sees two decoded instructions: the older one that has just moved into execute, and the younger one waiting in decode. When the younger instruction needs a result the older one cannot hand over in time, the block asks for a stall. The producers that can cause this are a word or double-word load, a multiply and a divide. The block also reports how many bubbles are needed. While the stall is up, the decode stage and the fetch stage keep their contents, and the pipeline puts a no-op into execute in place of the held instruction.

The decode descriptor is a valid/ready stream. A descriptor transfers when `dec_valid` and `dec_ready` are both high. While `dec_ready` is low, the producer of the stream must keep `dec_valid` and every descriptor field unchanged.

A stall of several bubbles is counted down inside the block. After the first cycle of such a stall, the execute-side inputs are ignored, because the pipeline is feeding bubbles into execute during those cycles. The pipeline accepts the hold when `stall` rises and releases it after exactly `bubbles` cycles. Every memory access is assumed to hit.

Top module: `ld_mul_interlock`

## Requirements
- R1: After reset, and after a reset that lands in the middle of a countdown, `stall` is 0, `bubbles` is 0 and `dec_ready` is 1 when both valids are low.
- R2: A single load (class 1) followed by a consumer that uses a source equal to the load's destination gives exactly 1 bubble. If no used source matches, or the matching source has its use bit clear, there are 0 bubbles.
- R3: A double-word load (class 2) writes a register pair: its destination with bit 0 cleared and with bit 0 set. It always costs at least 1 bubble, for its second cycle. It costs 2 bubbles if the consumer uses either register of the pair.
- R4: When the consumer is a store (class 3), only the sources marked in `dec_addr_sel` (bit i marks source i as an address operand) can cause a stall. A match on a store-data source alone adds no bubble.
- R5: A multiply (class 4) followed by a consumer that uses its destination gives 1 bubble. A Y-register read (class 6) right after a multiply never stalls, whatever its source fields hold.
- R6: A multiply followed directly by a divide (class 5) gives exactly 2 bubbles, whatever the operands are.
- R7: A divide followed by a consumer that uses its destination gives 1 bubble. An independent consumer gives 0.
- R8: Register 0 never creates a dependency, whether as a single destination or as a source.
- R9: No stall arises when `ex_valid` or `dec_valid` is low. No stall arises behind ALU (class 0), store, Y-read or branch (class 7) producers. A producer that is two or more slots older than the consumer is no longer in execute, so it cannot cause a stall.
- R10: For a need of N bubbles, `stall` stays high for exactly N consecutive cycles, and `bubbles` reads N, N-1, …, 1 over those cycles. `dec_ready` equals the inverse of `stall`. Execute-side inputs are ignored after the first stall cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ex_valid | input | 1 | Execute slot holds a real instruction |
| ex_cls | input | 3 | Class of the execute instruction |
| ex_rd | input | REG_W | Destination register of the execute instruction |
| dec_valid | input | 1 | Decode descriptor is valid |
| dec_cls | input | 3 | Class of the decode instruction |
| dec_src | input | NSRC*REG_W | Source register numbers, source i in bits [i*REG_W +: REG_W] |
| dec_src_use | input | NSRC | Bit i set when source i is actually read |
| dec_addr_sel | input | NSRC | For stores, bit i set when source i is an address operand |
| dec_ready | output | 1 | Decode descriptor may advance |
| stall | output | 1 | Hold decode and fetch, and inject a no-op into execute |
| bubbles | output | CNT_W | Bubbles still to be inserted, counting this cycle |

## Verification
Each producer class is paired with consumers that read the result through the first source, through the second source, not at all, or only through a source whose use bit is clear. This separates a real dependency from a field that merely holds a matching number. Store consumers are tried with the matching register in an address position and in a data position, which shows that the address mask is honoured. The multiply is followed by a Y-register read whose fields match and by divides with and without dependency, which separates the three multiply rules. Directed sequences cover double-word pairs, register 0, countdowns where the execute inputs change part-way, and a reset during a countdown.

// File: rtl/ilk_pkg.sv
package ilk_pkg;
  typedef enum logic [2:0] {
    CLS_ALU = 3'd0,
    CLS_LD  = 3'd1,
    CLS_LDD = 3'd2,
    CLS_ST  = 3'd3,
    CLS_MUL = 3'd4,
    CLS_DIV = 3'd5,
    CLS_RDY = 3'd6,
    CLS_BR  = 3'd7
  } op_cls_e;
endpackage

// File: rtl/ilk_dep_match.sv
// Compares one producer destination (optionally a register pair) with every
// consumer source; register 0 never matches.
module ilk_dep_match #(
  parameter int REG_W = 5,
  parameter int NSRC  = 2
) (
  input  logic [REG_W-1:0]      dst,
  input  logic                  dst_pair,
  input  logic [NSRC*REG_W-1:0] src,
  input  logic [NSRC-1:0]       src_use,
  input  logic [NSRC-1:0]       src_mask,
  output logic [NSRC-1:0]       hit
);
  for (genvar i = 0; i < NSRC; i++) begin : g_src
    logic [REG_W-1:0] s;
    logic             same;
    always_comb begin
      s    = src[i*REG_W +: REG_W];
      same = dst_pair ? (s[REG_W-1:1] == dst[REG_W-1:1]) : (s == dst);
      hit[i] = src_use[i] & src_mask[i] & (s != '0) & same;
    end
  end
endmodule

// File: rtl/ilk_bubble_calc.sv
// Works out how many bubbles the execute/decode pair needs.
module ilk_bubble_calc
  import ilk_pkg::*;
#(
  parameter int REG_W = 5,
  parameter int NSRC  = 2,
  parameter int CNT_W = 2
) (
  input  logic                  ex_valid,
  input  logic [2:0]            ex_cls,
  input  logic [REG_W-1:0]      ex_rd,
  input  logic                  dec_valid,
  input  logic [2:0]            dec_cls,
  input  logic [NSRC*REG_W-1:0] dec_src,
  input  logic [NSRC-1:0]       dec_src_use,
  input  logic [NSRC-1:0]       dec_addr_sel,
  output logic [CNT_W-1:0]      need
);
  op_cls_e         pcls, ccls;
  logic [NSRC-1:0] mask, use_eff, hit;
  logic            any_hit;

  always_comb begin
    pcls    = op_cls_e'(ex_cls);
    ccls    = op_cls_e'(dec_cls);
    // store consumers only care about their address operands
    mask    = (ccls == CLS_ST) ? dec_addr_sel : '1;
    // a Y-register read has no general-register source
    use_eff = (ccls == CLS_RDY) ? '0 : dec_src_use;
  end

  ilk_dep_match #(.REG_W(REG_W), .NSRC(NSRC)) u_match (
    .dst      (ex_rd),
    .dst_pair (pcls == CLS_LDD),
    .src      (dec_src),
    .src_use  (use_eff),
    .src_mask (mask),
    .hit      (hit)
  );

  assign any_hit = |hit;

  always_comb begin
    need = '0;
    if (ex_valid && dec_valid) begin
      unique case (pcls)
        CLS_LD:  need = any_hit ? CNT_W'(1) : '0;
        CLS_LDD: need = any_hit ? CNT_W'(2) : CNT_W'(1);
        CLS_MUL: need = (ccls == CLS_DIV) ? CNT_W'(2) :
                        (any_hit ? CNT_W'(1) : '0);
        CLS_DIV: need = any_hit ? CNT_W'(1) : '0;
        default: need = '0;
      endcase
    end
  end

  // R5: a Y read behind a multiply must not stall
  always_comb begin
    if (ex_valid && dec_valid && pcls == CLS_MUL && ccls == CLS_RDY)
      assert_rdy_R5: assert (need == '0) else $error("Y read stalled");
  end

  // R4: a store whose address operands all miss adds nothing behind a load
  always_comb begin
    if (ex_valid && dec_valid && pcls == CLS_LD && ccls == CLS_ST &&
        (hit & dec_addr_sel) == '0)
      assert_stdata_R4: assert (need == '0) else $error("store data stalled");
  end
endmodule

// File: rtl/ilk_stall_seq.sv
// Holds the remaining bubble count of a multi-cycle stall.
module ilk_stall_seq #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] need,
  output logic             stall,
  output logic [CNT_W-1:0] bubbles,
  output logic             busy
);
  logic [CNT_W-1:0] rem_q, rem_d;

  always_comb begin
    busy    = (rem_q != '0);
    bubbles = busy ? rem_q : need;
    stall   = (bubbles != '0);
    rem_d   = stall ? CNT_W'(bubbles - CNT_W'(1)) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rem_q <= '0;
    else        rem_q <= rem_d;
  end

  // R10: the count falls by one each cycle while more than one remains
  assert_countdown_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && bubbles > CNT_W'(1)) |=>
      (stall && bubbles == CNT_W'($past(bubbles) - CNT_W'(1))));

  // R10: the last bubble frees the hold for the next cycle
  assert_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && bubbles == CNT_W'(1)) |=> !busy);
endmodule

// File: rtl/ld_mul_interlock.sv
module ld_mul_interlock
  import ilk_pkg::*;
#(
  parameter int REG_W = 5,
  parameter int NSRC  = 2,
  parameter int CNT_W = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ex_valid,
  input  logic [2:0]            ex_cls,
  input  logic [REG_W-1:0]      ex_rd,
  input  logic                  dec_valid,
  input  logic [2:0]            dec_cls,
  input  logic [NSRC*REG_W-1:0] dec_src,
  input  logic [NSRC-1:0]       dec_src_use,
  input  logic [NSRC-1:0]       dec_addr_sel,
  output logic                  dec_ready,
  output logic                  stall,
  output logic [CNT_W-1:0]      bubbles
);
  logic [CNT_W-1:0] need;
  logic             busy;

  ilk_bubble_calc #(.REG_W(REG_W), .NSRC(NSRC), .CNT_W(CNT_W)) u_calc (
    .ex_valid     (ex_valid),
    .ex_cls       (ex_cls),
    .ex_rd        (ex_rd),
    .dec_valid    (dec_valid),
    .dec_cls      (dec_cls),
    .dec_src      (dec_src),
    .dec_src_use  (dec_src_use),
    .dec_addr_sel (dec_addr_sel),
    .need         (need)
  );

  ilk_stall_seq #(.CNT_W(CNT_W)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .need    (need),
    .stall   (stall),
    .bubbles (bubbles),
    .busy    (busy)
  );

  assign dec_ready = ~stall;

  // R9: nothing to interlock when either slot is empty
  assert_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && (!ex_valid || !dec_valid)) |-> !stall);

  // R3: a double-word load always costs its second cycle
  assert_ldd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && ex_valid && dec_valid && ex_cls == CLS_LDD) |-> stall);

  // R6: multiply then divide costs two bubbles
  assert_muldiv_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && ex_valid && dec_valid && ex_cls == CLS_MUL && dec_cls == CLS_DIV)
      |-> (bubbles == CNT_W'(2)));

  // R8: a load into register 0 creates no hazard
  assert_r0_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && ex_valid && ex_cls == CLS_LD && ex_rd == '0) |-> !stall);
endmodule

// File: tb/tb_ld_mul_interlock.sv
module tb_ld_mul_interlock;
  localparam int REG_W = 5;
  localparam int NSRC  = 2;
  localparam int CNT_W = 2;
  localparam int NV    = 23;

  logic                  clk = 1'b0;
  logic                  rst_n;
  logic                  ex_valid;
  logic [2:0]            ex_cls;
  logic [REG_W-1:0]      ex_rd;
  logic                  dec_valid;
  logic [2:0]            dec_cls;
  logic [NSRC*REG_W-1:0] dec_src;
  logic [NSRC-1:0]       dec_src_use;
  logic [NSRC-1:0]       dec_addr_sel;
  logic                  dec_ready;
  logic                  stall;
  logic [CNT_W-1:0]      bubbles;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  ld_mul_interlock #(.REG_W(REG_W), .NSRC(NSRC), .CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n),
    .ex_valid(ex_valid), .ex_cls(ex_cls), .ex_rd(ex_rd),
    .dec_valid(dec_valid), .dec_cls(dec_cls), .dec_src(dec_src),
    .dec_src_use(dec_src_use), .dec_addr_sel(dec_addr_sel),
    .dec_ready(dec_ready), .stall(stall), .bubbles(bubbles)
  );

  // {req[4], ev, ecls[3], erd[5], dv, dcls[3], s0[5], s1[5], use[2], asel[2], exp[2]}
  // source 0 is the low field of dec_src; use/asel bit 0 belong to source 0
  localparam logic [32:0] VEC [NV] = '{
    {4'd2, 1'b1,3'd1,5'd3,  1'b1,3'd0,5'd3, 5'd4, 2'b01,2'b00,2'd1}, // R2 src0
    {4'd2, 1'b1,3'd1,5'd3,  1'b1,3'd0,5'd4, 5'd3, 2'b11,2'b00,2'd1}, // R2 src1
    {4'd2, 1'b1,3'd1,5'd3,  1'b1,3'd0,5'd4, 5'd5, 2'b11,2'b00,2'd0}, // R2 independent
    {4'd2, 1'b1,3'd1,5'd3,  1'b1,3'd0,5'd3, 5'd3, 2'b00,2'b00,2'd0}, // R2 unused field
    {4'd4, 1'b1,3'd1,5'd3,  1'b1,3'd3,5'd4, 5'd3, 2'b11,2'b01,2'd0}, // R4 data only
    {4'd4, 1'b1,3'd1,5'd3,  1'b1,3'd3,5'd3, 5'd4, 2'b11,2'b01,2'd1}, // R4 address
    {4'd4, 1'b1,3'd4,5'd6,  1'b1,3'd3,5'd2, 5'd6, 2'b11,2'b01,2'd0}, // R4 mul data
    {4'd4, 1'b1,3'd4,5'd6,  1'b1,3'd3,5'd2, 5'd6, 2'b11,2'b11,2'd1}, // R4 both address
    {4'd5, 1'b1,3'd4,5'd6,  1'b1,3'd0,5'd1, 5'd6, 2'b11,2'b00,2'd1}, // R5 mul use
    {4'd5, 1'b1,3'd4,5'd6,  1'b1,3'd6,5'd6, 5'd6, 2'b11,2'b00,2'd0}, // R5 Y read
    {4'd5, 1'b1,3'd4,5'd6,  1'b1,3'd0,5'd7, 5'd8, 2'b11,2'b00,2'd0}, // R5 independent
    {4'd6, 1'b1,3'd4,5'd6,  1'b1,3'd5,5'd1, 5'd2, 2'b11,2'b00,2'd2}, // R6 no dep
    {4'd6, 1'b1,3'd4,5'd6,  1'b1,3'd5,5'd6, 5'd2, 2'b11,2'b00,2'd2}, // R6 dep
    {4'd7, 1'b1,3'd5,5'd9,  1'b1,3'd0,5'd9, 5'd1, 2'b11,2'b00,2'd1}, // R7 dep
    {4'd7, 1'b1,3'd5,5'd9,  1'b1,3'd0,5'd8, 5'd1, 2'b11,2'b00,2'd0}, // R7 indep
    {4'd3, 1'b1,3'd2,5'd4,  1'b1,3'd0,5'd7, 5'd1, 2'b11,2'b00,2'd1}, // R3 occupancy
    {4'd3, 1'b1,3'd2,5'd4,  1'b1,3'd0,5'd5, 5'd1, 2'b11,2'b00,2'd2}, // R3 odd half
    {4'd3, 1'b1,3'd2,5'd4,  1'b1,3'd3,5'd1, 5'd4, 2'b11,2'b01,2'd1}, // R3 store data
    {4'd8, 1'b1,3'd1,5'd0,  1'b1,3'd0,5'd0, 5'd0, 2'b11,2'b00,2'd0}, // R8 load r0
    {4'd8, 1'b1,3'd4,5'd0,  1'b1,3'd0,5'd0, 5'd2, 2'b11,2'b00,2'd0}, // R8 mul r0
    {4'd9, 1'b1,3'd0,5'd3,  1'b1,3'd0,5'd3, 5'd3, 2'b11,2'b00,2'd0}, // R9 alu
    {4'd9, 1'b0,3'd1,5'd3,  1'b1,3'd0,5'd3, 5'd3, 2'b11,2'b00,2'd0}, // R9 ex empty
    {4'd9, 1'b1,3'd1,5'd3,  1'b0,3'd0,5'd3, 5'd3, 2'b11,2'b00,2'd0}  // R9 dec empty
  };

  task automatic drive_idle();
    ex_valid = 0; ex_cls = 3'd0; ex_rd = '0;
    dec_valid = 0; dec_cls = 3'd0; dec_src = '0;
    dec_src_use = '0; dec_addr_sel = '0;
  endtask

  task automatic drive(input logic ev, input logic [2:0] ec, input logic [4:0] er,
                       input logic dv, input logic [2:0] dc, input logic [4:0] s0,
                       input logic [4:0] s1, input logic [1:0] u, input logic [1:0] a);
    ex_valid = ev; ex_cls = ec; ex_rd = er;
    dec_valid = dv; dec_cls = dc; dec_src = {s1, s0};
    dec_src_use = u; dec_addr_sel = a;
  endtask

  task automatic chk(input string req, input logic [1:0] exp);
    checks++;
    if (stall !== (exp != 0) || bubbles !== exp || dec_ready !== (exp == 0)) begin
      fails++;
      $display("FAIL %s: stall=%0b bubbles=%0d ready=%0b expected stall=%0b bubbles=%0d ready=%0b",
               req, stall, bubbles, dec_ready, exp != 0, exp, exp == 0);
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0;
    drive_idle();
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R1", 2'd0);

    // table walk: each pair with a fresh countdown
    for (int i = 0; i < NV; i++) begin
      logic [32:0] v;
      v = VEC[i];
      @(posedge clk); #1;
      drive(v[28], v[27:25], v[24:20], v[19], v[18:16], v[15:11], v[10:6],
            v[5:4], v[3:2]);
      @(negedge clk);
      chk($sformatf("R%0d vec%0d", v[32:29], i), v[1:0]);
      @(posedge clk); #1 drive_idle();
      repeat (3) @(posedge clk);
    end

    // R3 and R8: double-word load into r0 still writes r1
    @(posedge clk); #1 drive(1, 3'd2, 5'd0, 1, 3'd0, 5'd1, 5'd0, 2'b01, 2'b00);
    @(negedge clk); chk("R3 R8 pair r0/r1", 2'd2);
    @(posedge clk); #1 drive_idle();
    repeat (3) @(posedge clk);

    // R10: two-bubble countdown; execute inputs changed mid-stall are ignored
    @(posedge clk); #1 drive(1, 3'd4, 5'd6, 1, 3'd5, 5'd1, 5'd2, 2'b11, 2'b00);
    @(negedge clk); chk("R10 first of two", 2'd2);
    @(posedge clk); #1 drive(1, 3'd2, 5'd4, 1, 3'd5, 5'd4, 5'd2, 2'b11, 2'b00);
    @(negedge clk); chk("R10 second of two", 2'd1);
    @(posedge clk); #1 drive(0, 3'd0, 5'd0, 1, 3'd5, 5'd4, 5'd2, 2'b11, 2'b00);
    @(negedge clk); chk("R10 released", 2'd0);
    @(posedge clk); #1 drive_idle();

    // R10: single bubble then release with decode still valid
    @(posedge clk); #1 drive(1, 3'd1, 5'd3, 1, 3'd0, 5'd3, 5'd0, 2'b01, 2'b00);
    @(negedge clk); chk("R10 single", 2'd1);
    @(posedge clk); #1 drive(0, 3'd0, 5'd0, 1, 3'd0, 5'd3, 5'd0, 2'b01, 2'b00);
    @(negedge clk); chk("R10 single released", 2'd0);
    @(posedge clk); #1 drive_idle();

    // R9: load, unrelated instruction, then the consumer: no bubble
    @(posedge clk); #1 drive(1, 3'd0, 5'd9, 1, 3'd0, 5'd3, 5'd0, 2'b01, 2'b00);
    @(negedge clk); chk("R9 one slot gap", 2'd0);
    @(posedge clk); #1 drive_idle();

    // R1: reset during a countdown clears it
    @(posedge clk); #1 drive(1, 3'd4, 5'd6, 1, 3'd5, 5'd1, 5'd2, 2'b11, 2'b00);
    @(negedge clk); chk("R1 pre-reset stall", 2'd2);
    @(posedge clk); #1 begin drive_idle(); rst_n = 0; end
    @(negedge clk); chk("R1 reset mid-countdown", 2'd0);
    @(posedge clk); #1 rst_n = 1;
    @(negedge clk); chk("R1 after reset", 2'd0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule